// File: doc/BRIEF.md
# Toll Lane Payment Controller

This block controls a single toll lane. A sensor bit says whether a car is standing at the booth, and a 2-bit code reports the coin inserted in each clock cycle. The controller adds up the coins paid by the current car and compares the total with a fixed toll. It drives a red lamp, a green lamp and an alarm.

While a car owes money, the red lamp is lit. Once the total reaches the toll, the lamp turns green. The green lamp stays on until the car drives away, and the lane then goes dark. A car that drives away before paying in full leaves red and alarm lit together. Both stay lit until the next car pulls in.

All three outputs are registered and depend only on the controller's state. An input change is therefore never seen at the outputs before the next clock edge.

Top module: `toll_lane_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in its idle state, clears the running total and drives red, green and alarm to 0 after the edge.
- R2: When a car arrives (car goes 1) and the total is still below the toll, the outputs are red=1, green=0, alarm=0.
- R3: Coin codes are 00 = no coin, 01 = 5 units, 10 = 10 units and 11 = 25 units. The code is sampled at every rising clock edge while car is 1, including the arrival edge, and added to the total.
- R4: When the total reaches the toll of 35 units exactly, the outputs become red=0, green=1, alarm=0 after the edge that added the last coin.
- R5: A total above the toll counts as paid and gives the same green outputs, with no change returned.
- R6: While paid and car stays 1, green stays 1 and further coins have no effect. When car falls to 0, all outputs return to 0 and the total is cleared.
- R7: If car falls to 0 while the toll is unpaid, red and alarm both become 1 with green 0. They hold while car stays 0, and coins have no effect.
- R8: From the alarm state, a new car arrival clears alarm (red=1, alarm=0 if still unpaid) and starts a fresh total. No coins from the previous car carry over.
- R9: In the idle state with car at 0, coin codes are ignored and the outputs stay 0.
- R10: Outputs change only at a rising clock edge. An input change between edges leaves the outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car | input | 1 | 1 while a car is at the booth |
| coin | input | 2 | Coin code sampled every edge |
| red | output | 1 | Red lamp |
| green | output | 1 | Green lamp |
| alarm | output | 1 | Alarm for a car that left unpaid |

## Verification
The bench pays exactly 35 units in steps of 5 and 10. A design with an off-by-one compare would either stay red there or turn green one coin too early.

A second car follows an alarm. If the previous car's coins leaked into its total, it would turn green too early. Coins offered with no car present are also checked, since counting them would shorten the next payment. The coin on the arrival edge itself is counted.

The bench changes car between edges. A combinational (Mealy) output path would show the alarm before the clock edge.

// File: rtl/toll_lane_ctrl.sv
module toll_lane_ctrl #(
  parameter int TOLL  = 35,
  parameter int VAL_A = 5,
  parameter int VAL_B = 10,
  parameter int VAL_C = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car,
  input  logic [1:0] coin,
  output logic       red,
  output logic       green,
  output logic       alarm
);
  localparam int TW = $clog2(TOLL + VAL_A + VAL_B + VAL_C + 1);
  localparam logic [TW-1:0] TOLL_W = TW'(TOLL);

  typedef enum logic [1:0] {IDLE, OWED, CLEAR, FLAG} st_t;

  st_t st, st_n;
  logic [TW-1:0] paid, paid_n, coin_v, sum;

  always_comb
    case (coin)
      2'b01:   coin_v = TW'(VAL_A);
      2'b10:   coin_v = TW'(VAL_B);
      2'b11:   coin_v = TW'(VAL_C);
      default: coin_v = '0;
    endcase

  assign sum = paid + coin_v;

  always_comb begin
    st_n   = st;
    paid_n = paid;
    case (st)
      IDLE, FLAG:
        if (car) begin
          paid_n = coin_v;
          st_n   = (coin_v >= TOLL_W) ? CLEAR : OWED;
        end
      OWED:
        if (!car) st_n = FLAG;
        else begin
          paid_n = sum;
          if (sum >= TOLL_W) st_n = CLEAR;
        end
      CLEAR:
        if (!car) begin
          st_n   = IDLE;
          paid_n = '0;
        end
      default: st_n = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= IDLE;
      paid  <= '0;
      red   <= 1'b0;
      green <= 1'b0;
      alarm <= 1'b0;
    end else begin
      st    <= st_n;
      paid  <= paid_n;
      red   <= (st_n == OWED) || (st_n == FLAG);
      green <= (st_n == CLEAR);
      alarm <= (st_n == FLAG);
    end
  end

  assert_reset_dark_R1: assert property (@(posedge clk)
    rst |=> !red && !green && !alarm);
  assert_green_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    green |-> !red && !alarm);
  assert_paid_holds_R6: assert property (@(posedge clk) disable iff (rst)
    green && car |=> green);
  assert_paid_leaves_R6: assert property (@(posedge clk) disable iff (rst)
    green && !car |=> !red && !green && !alarm);
  assert_alarm_with_red_R7: assert property (@(posedge clk) disable iff (rst)
    alarm |-> red);
  assert_unpaid_exit_R7: assert property (@(posedge clk) disable iff (rst)
    red && !alarm && !car |=> red && alarm && !green);
  assert_alarm_holds_R7: assert property (@(posedge clk) disable iff (rst)
    alarm && !car |=> alarm);
  assert_alarm_clears_R8: assert property (@(posedge clk) disable iff (rst)
    alarm && car |=> !alarm);
  assert_idle_ignores_R9: assert property (@(posedge clk) disable iff (rst)
    !red && !green && !alarm && !car |=> !red && !green && !alarm);
endmodule

// File: tb/sim_toll_lane_ctrl.sv
module sim_toll_lane_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, car = 1'b0;
  logic [1:0] coin = 2'b00;
  logic red, green, alarm;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  toll_lane_ctrl u0 (.clk(clk), .rst(rst), .car(car), .coin(coin),
                     .red(red), .green(green), .alarm(alarm));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic er, logic eg, logic ea);
    checks++;
    if ({red, green, alarm} !== {er, eg, ea}) begin
      fails++;
      $display("FAIL %s: rga=%b%b%b expected %b%b%b", tag, red, green, alarm, er, eg, ea);
    end
  endtask

  task automatic cyc(logic c, logic [1:0] i);
    @(negedge clk);
    car = c; coin = i;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(1'b1, 2'b11); cyc(1'b0, 2'b00);
    chk("R1 reset", 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_exact;
    cyc(1, 2'b00); chk("R2 arrival", 1, 0, 0);
    cyc(1, 2'b01); chk("R3 5", 1, 0, 0);
    cyc(1, 2'b10); chk("R3 15", 1, 0, 0);
    cyc(1, 2'b01); chk("R3 20", 1, 0, 0);
    cyc(1, 2'b10); chk("R3 30", 1, 0, 0);
    cyc(1, 2'b00); chk("R3 no coin", 1, 0, 0);
    cyc(1, 2'b01); chk("R4 exact 35", 0, 1, 0);
    cyc(0, 2'b00); chk("R6 leave", 0, 0, 0);
  endtask

  task automatic t_over;
    cyc(1, 2'b11); chk("R3 arrival coin 25", 1, 0, 0);
    cyc(1, 2'b11); chk("R5 overpay 50", 0, 1, 0);
    cyc(1, 2'b11); chk("R6 coin while paid", 0, 1, 0);
    cyc(1, 2'b00); chk("R6 hold", 0, 1, 0);
    cyc(0, 2'b11); chk("R6 leave", 0, 0, 0);
    cyc(1, 2'b10); chk("R6 total cleared", 1, 0, 0);
    cyc(1, 2'b10); chk("R6 20", 1, 0, 0);
    cyc(1, 2'b11); chk("R6 45", 0, 1, 0);
    cyc(0, 2'b00);
  endtask

  task automatic t_alarm;
    cyc(1, 2'b00); cyc(1, 2'b10); chk("R2 owes", 1, 0, 0);
    cyc(0, 2'b11); chk("R7 left unpaid", 1, 0, 1);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 2'b11); chk("R7 alarm hold", 1, 0, 1);
    end
    cyc(1, 2'b00); chk("R8 new car", 1, 0, 0);
    cyc(1, 2'b11); chk("R8 fresh total 25", 1, 0, 0);
    cyc(1, 2'b10); chk("R8 35 paid", 0, 1, 0);
    cyc(0, 2'b00);
  endtask

  task automatic t_idle_coins;
    cyc(0, 2'b11); chk("R9 idle coin", 0, 0, 0);
    cyc(0, 2'b11); chk("R9 idle coin", 0, 0, 0);
    cyc(1, 2'b00); chk("R9 arrival", 1, 0, 0);
    cyc(1, 2'b01); chk("R9 no credit", 1, 0, 0);
    cyc(0, 2'b00); cyc(1, 2'b00);
  endtask

  task automatic t_moore;
    cyc(1, 2'b01); chk("R10 owes", 1, 0, 0);
    @(negedge clk); car = 1'b0;
    #(PERIOD/4); chk("R10 no change before edge", 1, 0, 0);
    @(posedge clk); #(PERIOD/4); chk("R10 after edge", 1, 0, 1);
  endtask

  task automatic t_reset_mid;
    cyc(1, 2'b10); chk("R8 arrival", 1, 0, 0);
    @(negedge clk); rst = 1'b1; car = 1'b1; coin = 2'b11;
    @(posedge clk); #(PERIOD/4); chk("R1 reset mid-payment", 0, 0, 0);
    @(negedge clk); rst = 1'b0; car = 1'b0; coin = 2'b00;
    cyc(1, 2'b11); chk("R1 fresh 25", 1, 0, 0);
    cyc(1, 2'b10); chk("R1 fresh 35", 0, 1, 0);
    cyc(0, 2'b00); chk("R6 leave", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_exact();
    t_over();
    t_alarm();
    t_idle_coins();
    t_moore();
    t_reset_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule